// File: doc/BRIEF.md
# Indexed-Colour Palette with Sequenced Host Port

This block turns a pixel code into red, green and blue intensities for a display pipeline. It contains a 256-entry colour table. Each entry holds three 4-bit components. The host loads the table through a byte-wide port with two targets: an index register and a single data register.

To load colours, the host first writes the entry number to the index register. It then writes three bytes to the data register, in the order red, green, blue. The block keeps the first two components and writes the whole entry on the third byte. It then moves on to the next entry, so a run of entries can be loaded with one index write.

On the pixel side, a 3-bit format select picks one of three formats: a 16-colour indexed format, a 256-colour indexed format, or 16-bit direct colour. Direct colour does not use the table. In every format the result appears at the outputs exactly one clock after the pixel and format code are presented. Each output component is 8 bits wide. It is widened from the stored or direct field by repeating the field's most significant bits into the low bits.

Top module: `clut_top`

## Requirements
- R1: A host write with `host_sel` = 0 loads `host_wdata` as the current entry index.
- R2: An index write restarts the component sequence, so the next data write is taken as red. Any red or green already collected is discarded, and no entry is changed.
- R3: With `host_sel` = 1, three host writes supply red, green and blue in that order. Each component is taken from `host_wdata[7:4]`. The entry is written on the blue write, and a pixel lookup presented in any later cycle sees it.
- R4: After each blue write the current index increases by one, wrapping from 255 to 0.
- R5: Format code 3 (256-colour indexed) looks up the entry addressed by `pix_in[7:0]` and ignores `pix_in[15:8]`. Each 4-bit stored component c is output as {c, c}.
- R6: Format code 2 (16-colour indexed) looks up the entry addressed by `pix_in[3:0]`, with the upper index bits forced to zero.
- R7: Format code 5 (direct colour) bypasses the table. Red is `pix_in[15:11]`, output as {r, r[4:2]}. Green is `pix_in[10:5]`, output as {g, g[5:4]}. Blue is `pix_in[4:0]`, output as {b, b[4:2]}.
- R8: Format codes 0, 1, 4, 6 and 7 produce zero on all three outputs.
- R9: In every format the outputs reflect the pixel and format code sampled at the previous rising clock edge. A new pixel can be presented in every cycle.
- R10: When a blue write and a lookup of the same entry happen in the same cycle, the lookup returns the entry's previous contents.
- R11: After a synchronous reset the outputs are zero, the current index is 0 and the next data write is taken as red. Table contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host write strobe, one write per cycle it is high |
| host_sel | input | 1 | Write target: 0 = index register, 1 = data register |
| host_wdata | input | 8 | Host write byte |
| fmt_sel | input | 3 | Pixel format code |
| pix_in | input | 16 | Pixel code or direct colour word |
| out_red | output | 8 | Red intensity |
| out_green | output | 8 | Green intensity |
| out_blue | output | 8 | Blue intensity |

## Verification
The table is loaded with distinct nibbles in each component, both as separate runs and as one run that crosses the wrap from 255 to 0. This separates component-order errors from index-step errors. Lookups in the 16-colour format use pixel codes whose upper nibble points at a different, also loaded, entry, so a missing mask shows up as a wrong colour rather than an unknown one. Direct-colour words with only one field set tell a swapped or shifted field apart from a bad widening. A back-to-back stream that changes format every cycle, plus a lookup that collides with the committing write, pins down the one-cycle alignment and the read-before-write order.

// File: rtl/clut_pkg.sv
// Package: shared constants and types for the colour lookup block.
// Assumes an 8-bit output per component and a 5/6/5 direct-colour word.
package clut_pkg;

    // Output component width after bit replication
    localparam int CLUT_OUT_W = 8;

    // Direct-colour field widths, most significant field first
    localparam int DIR_R_W = 5;
    localparam int DIR_G_W = 6;
    localparam int DIR_B_W = 5;
    localparam int PIX_W   = DIR_R_W + DIR_G_W + DIR_B_W;

    // Pixel format codes
    localparam logic [2:0] FMT_IDX16  = 3'd2;
    localparam logic [2:0] FMT_IDX256 = 3'd3;
    localparam logic [2:0] FMT_DIRECT = 3'd5;

    // Host write targets
    localparam logic HOST_TGT_INDEX = 1'b0;
    localparam logic HOST_TGT_DATA  = 1'b1;

    // Component sequencer position
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_t;

endpackage

// File: rtl/clut_expand.sv
// Module: clut_expand
// Widens a colour field to OUT_W bits by repeating its bits from the
// most significant end, so full scale maps to full scale.
// Assumes IN_W >= 1 and IN_W <= OUT_W.
module clut_expand #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  field_in,
    output logic [OUT_W-1:0] wide_out
);

    // Each output bit takes the input bit at the same distance from the
    // top, modulo the input width
    for (genvar i = 0; i < OUT_W; i++) begin : g_rep
        assign wide_out[OUT_W-1-i] = field_in[IN_W-1-(i % IN_W)];
    end

endmodule

// File: rtl/clut_host_seq.sv
// Module: clut_host_seq
// Host side of the colour table. It holds the current entry index and
// collects red and green from successive data writes. On the blue write it
// issues one table write and steps the index.
// Assumes at most one host write per cycle and components in the top
// COMP_W bits of each data byte.
module clut_host_seq
    import clut_pkg::*;
#(
    parameter int HOST_W = 8,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic                host_sel,
    input  logic [HOST_W-1:0]   host_wdata,
    output logic                tbl_we,
    output logic [IDX_W-1:0]    tbl_waddr,
    output logic [3*COMP_W-1:0] tbl_wdata
);

    localparam int ENTRY_W = 3 * COMP_W;

    comp_phase_t          phase_q;
    logic [IDX_W-1:0]     idx_q;
    logic [COMP_W-1:0]    red_q;
    logic [COMP_W-1:0]    green_q;
    logic [COMP_W-1:0]    comp_in;
    logic                 idx_wr;
    logic                 dat_wr;

    assign idx_wr  = host_we && (host_sel == HOST_TGT_INDEX);
    assign dat_wr  = host_we && (host_sel == HOST_TGT_DATA);
    assign comp_in = host_wdata[HOST_W-1 -: COMP_W];

    // Index register, component phase and staged red/green
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
            red_q   <= '0;
            green_q <= '0;
        end else if (idx_wr) begin
            idx_q   <= host_wdata[IDX_W-1:0];
            phase_q <= PH_RED;
        end else if (dat_wr) begin
            case (phase_q)
                PH_RED: begin
                    red_q   <= comp_in;
                    phase_q <= PH_GREEN;
                end
                PH_GREEN: begin
                    green_q <= comp_in;
                    phase_q <= PH_BLUE;
                end
                default: begin
                    idx_q   <= idx_q + 1'b1;
                    phase_q <= PH_RED;
                end
            endcase
        end
    end

    // Table write issued on the blue data write
    always_comb begin
        tbl_we    = dat_wr && (phase_q == PH_BLUE);
        tbl_waddr = idx_q;
        tbl_wdata = ENTRY_W'({red_q, green_q, comp_in});
    end

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(host_wdata[IDX_W-1:0]))); // R1

    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (phase_q == PH_RED)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> ($stable(idx_q) && $stable(phase_q))); // R3

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> (idx_q == $past(idx_q) + 1'b1)); // R4

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3); // R3

endmodule

// File: rtl/clut_store.sv
// Module: clut_store
// Colour table storage: one write port from the host side and one
// registered read port for the pixel side. A read of an entry being
// written in the same cycle returns the old contents.
// Assumes contents are not reset; the read register is.
module clut_store #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Table write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered lookup, old data on a same-entry collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/clut_pixel_path.sv
// Module: clut_pixel_path
// Pixel side: forms the table address for the indexed formats and keeps
// the direct-colour word and format code for one cycle. It then picks and
// widens the components. Every format has one clock of latency.
// Assumes tbl_rd_data is the registered table output for the address
// presented in the previous cycle.
module clut_pixel_path
    import clut_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int NARROW_W    = 4,
    parameter int COMP_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            fmt_sel,
    input  logic [PIX_W-1:0]      pix_in,
    output logic [IDX_W-1:0]      tbl_rd_addr,
    input  logic [3*COMP_W-1:0]   tbl_rd_data,
    output logic [CLUT_OUT_W-1:0] out_red,
    output logic [CLUT_OUT_W-1:0] out_green,
    output logic [CLUT_OUT_W-1:0] out_blue
);

    logic [2:0]            fmt_q;
    logic [PIX_W-1:0]      pix_q;
    logic [CLUT_OUT_W-1:0] idx_r, idx_g, idx_b;
    logic [CLUT_OUT_W-1:0] dir_r, dir_g, dir_b;

    // Table address: the narrow format keeps only the low NARROW_W bits
    always_comb begin
        tbl_rd_addr = pix_in[IDX_W-1:0];
        if (fmt_sel == FMT_IDX16) begin
            tbl_rd_addr = IDX_W'(pix_in[NARROW_W-1:0]);
        end
    end

    // Format code and direct word aligned with the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= '0;
            pix_q <= '0;
        end else begin
            fmt_q <= fmt_sel;
            pix_q <= pix_in;
        end
    end

    clut_expand #(.IN_W(COMP_W), .OUT_W(CLUT_OUT_W)) u_idx_r (
        .field_in (tbl_rd_data[3*COMP_W-1 -: COMP_W]),
        .wide_out (idx_r)
    );
    clut_expand #(.IN_W(COMP_W), .OUT_W(CLUT_OUT_W)) u_idx_g (
        .field_in (tbl_rd_data[2*COMP_W-1 -: COMP_W]),
        .wide_out (idx_g)
    );
    clut_expand #(.IN_W(COMP_W), .OUT_W(CLUT_OUT_W)) u_idx_b (
        .field_in (tbl_rd_data[COMP_W-1:0]),
        .wide_out (idx_b)
    );

    clut_expand #(.IN_W(DIR_R_W), .OUT_W(CLUT_OUT_W)) u_dir_r (
        .field_in (pix_q[PIX_W-1 -: DIR_R_W]),
        .wide_out (dir_r)
    );
    clut_expand #(.IN_W(DIR_G_W), .OUT_W(CLUT_OUT_W)) u_dir_g (
        .field_in (pix_q[DIR_B_W +: DIR_G_W]),
        .wide_out (dir_g)
    );
    clut_expand #(.IN_W(DIR_B_W), .OUT_W(CLUT_OUT_W)) u_dir_b (
        .field_in (pix_q[DIR_B_W-1:0]),
        .wide_out (dir_b)
    );

    // Output select by the registered format code; others give black
    always_comb begin
        case (fmt_q)
            FMT_IDX16, FMT_IDX256: begin
                out_red   = idx_r;
                out_green = idx_g;
                out_blue  = idx_b;
            end
            FMT_DIRECT: begin
                out_red   = dir_r;
                out_green = dir_g;
                out_blue  = dir_b;
            end
            default: begin
                out_red   = '0;
                out_green = '0;
                out_blue  = '0;
            end
        endcase
    end

    AST_BLACK_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel != FMT_IDX16 && fmt_sel != FMT_IDX256 && fmt_sel != FMT_DIRECT)
        |=> (out_red == '0 && out_green == '0 && out_blue == '0)); // R8

    AST_DIRECT_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == FMT_DIRECT)
        |=> (out_red[CLUT_OUT_W-1 -: DIR_R_W] == $past(pix_in[PIX_W-1 -: DIR_R_W]))); // R7

    AST_DIRECT_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == FMT_DIRECT)
        |=> (out_blue[CLUT_OUT_W-1 -: DIR_B_W] == $past(pix_in[DIR_B_W-1:0]))); // R7

    AST_INDEXED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == FMT_IDX256)
        |=> (out_green[CLUT_OUT_W-1 -: COMP_W] == tbl_rd_data[2*COMP_W-1 -: COMP_W])); // R9

endmodule

// File: rtl/clut_top.sv
// Module: clut_top
// Colour lookup block: byte-wide host loading of a 256-entry palette
// through an index register and a sequenced data register, plus a
// one-cycle pixel path supporting two indexed formats and direct colour.
// Assumes host writes and pixels share one clock.
module clut_top
    import clut_pkg::*;
#(
    parameter int HOST_W   = 8,
    parameter int IDX_W    = 8,
    parameter int COMP_W   = 4,
    parameter int NARROW_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we,
    input  logic                  host_sel,
    input  logic [HOST_W-1:0]     host_wdata,
    input  logic [2:0]            fmt_sel,
    input  logic [PIX_W-1:0]      pix_in,
    output logic [CLUT_OUT_W-1:0] out_red,
    output logic [CLUT_OUT_W-1:0] out_green,
    output logic [CLUT_OUT_W-1:0] out_blue
);

    localparam int ENTRY_W = 3 * COMP_W;

    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_waddr;
    logic [ENTRY_W-1:0] tbl_wdata;
    logic [IDX_W-1:0]   tbl_raddr;
    logic [ENTRY_W-1:0] tbl_rdata;

    clut_host_seq #(
        .HOST_W (HOST_W),
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .tbl_we     (tbl_we),
        .tbl_waddr  (tbl_waddr),
        .tbl_wdata  (tbl_wdata)
    );

    clut_store #(
        .IDX_W   (IDX_W),
        .ENTRY_W (ENTRY_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_waddr),
        .wr_data (tbl_wdata),
        .rd_addr (tbl_raddr),
        .rd_data (tbl_rdata)
    );

    clut_pixel_path #(
        .IDX_W    (IDX_W),
        .NARROW_W (NARROW_W),
        .COMP_W   (COMP_W)
    ) u_pix (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_sel     (fmt_sel),
        .pix_in      (pix_in),
        .tbl_rd_addr (tbl_raddr),
        .tbl_rd_data (tbl_rdata),
        .out_red     (out_red),
        .out_green   (out_green),
        .out_blue    (out_blue)
    );

    AST_RESET_BLACK: assert property (@(posedge clk)
        !rst_n |=> (out_red == '0 && out_green == '0 && out_blue == '0)); // R11

endmodule

// File: tb/clut_top_test.sv
// Bench for clut_top: directed scenarios, one task each, with a shadow
// palette built from the requirements.
module clut_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [2:0]  fmt_sel = '0;
    logic [15:0] pix_in = '0;
    logic [7:0]  out_red, out_green, out_blue;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Shadow of the requirements-level state
    logic [11:0] shadow [256];
    logic [7:0]  m_idx = '0;
    int          m_phase = 0;
    logic [3:0]  m_red, m_green;

    clut_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .fmt_sel    (fmt_sel),
        .pix_in     (pix_in),
        .out_red    (out_red),
        .out_green  (out_green),
        .out_blue   (out_blue)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_fail++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] w4(input logic [3:0] c);
        return {c, c};
    endfunction
    function automatic logic [7:0] w5(input logic [4:0] c);
        return {c, c[4:2]};
    endfunction
    function automatic logic [7:0] w6(input logic [5:0] c);
        return {c, c[5:4]};
    endfunction

    task automatic check_rgb(input string req, input logic [7:0] er,
                             input logic [7:0] eg, input logic [7:0] eb);
        n_checks++;
        if (out_red !== er || out_green !== eg || out_blue !== eb) begin
            n_fail++;
            $display("FAIL %s: got %h/%h/%h expected %h/%h/%h",
                     req, out_red, out_green, out_blue, er, eg, eb);
        end
    endtask

    task automatic check_entry(input string req, input logic [7:0] e);
        check_rgb(req, w4(shadow[e][11:8]), w4(shadow[e][7:4]), w4(shadow[e][3:0]));
    endtask

    // Host write with model update; the write lands at the middle edge
    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        if (sel == 1'b0) begin
            m_idx = d; m_phase = 0;
        end else if (m_phase == 0) begin
            m_red = d[7:4]; m_phase = 1;
        end else if (m_phase == 1) begin
            m_green = d[7:4]; m_phase = 2;
        end else begin
            shadow[m_idx] = {m_red, m_green, d[7:4]};
            m_idx = m_idx + 8'd1; m_phase = 0;
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic load_entry(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        host_write(1'b1, r);
        host_write(1'b1, g);
        host_write(1'b1, b);
    endtask

    // Present one pixel, check one cycle later
    task automatic lookup(input logic [2:0] f, input logic [15:0] p);
        @(negedge clk);
        fmt_sel = f; pix_in = p;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_rgb("R11 reset outputs", 8'h00, 8'h00, 8'h00);
        // No index write: loads go to entry 0 starting with red
        load_entry(8'h10, 8'h20, 8'h3F);
        lookup(3'd3, 16'h0000);
        check_entry("R11 reset index and phase", 8'h00);
    endtask

    task automatic t_run_load;
        host_write(1'b0, 8'h10);
        load_entry(8'hA5, 8'h5A, 8'hC3);
        load_entry(8'h1F, 8'h2E, 8'h3D);
        load_entry(8'hF0, 8'h80, 8'h70);
        lookup(3'd3, 16'h0010);
        check_entry("R3 entry 0x10 component order", 8'h10);
        lookup(3'd3, 16'h0011);
        check_entry("R4 entry 0x11 index step", 8'h11);
        lookup(3'd3, 16'h0012);
        check_rgb("R1 entry 0x12 values", 8'hFF, 8'h88, 8'h77);
    endtask

    task automatic t_wrap;
        host_write(1'b0, 8'hFF);
        load_entry(8'h90, 8'hA0, 8'hB0);
        load_entry(8'h60, 8'h50, 8'h40);
        lookup(3'd3, 16'h00FF);
        check_entry("R4 entry 0xFF", 8'hFF);
        lookup(3'd3, 16'h0000);
        check_rgb("R4 wrap to entry 0", 8'h66, 8'h55, 8'h44);
    endtask

    task automatic t_restart;
        host_write(1'b0, 8'h40);
        load_entry(8'h70, 8'h70, 8'h70);
        host_write(1'b0, 8'h40);
        host_write(1'b1, 8'hE0);
        host_write(1'b1, 8'hD0);
        host_write(1'b0, 8'h41);
        load_entry(8'h20, 8'h30, 8'h40);
        lookup(3'd3, 16'h0041);
        check_rgb("R2 restart takes red first", 8'h22, 8'h33, 8'h44);
        lookup(3'd3, 16'h0040);
        check_rgb("R2 partial sequence discarded", 8'h77, 8'h77, 8'h77);
    endtask

    task automatic t_idx256;
        lookup(3'd3, 16'hAB10);
        check_entry("R5 upper pixel bits ignored", 8'h10);
    endtask

    task automatic t_idx16;
        host_write(1'b0, 8'h02);
        load_entry(8'h30, 8'hC0, 8'h90);
        host_write(1'b0, 8'h12);
        load_entry(8'hF0, 8'hF0, 8'hF0);
        lookup(3'd2, 16'h0012);
        check_rgb("R6 narrow index masked", 8'h33, 8'hCC, 8'h99);
        lookup(3'd3, 16'h0012);
        check_rgb("R6 wide index unmasked", 8'hFF, 8'hFF, 8'hFF);
    endtask

    task automatic t_direct;
        lookup(3'd5, 16'hF800);
        check_rgb("R7 direct red field", 8'hFF, 8'h00, 8'h00);
        lookup(3'd5, 16'h07E0);
        check_rgb("R7 direct green field", 8'h00, 8'hFF, 8'h00);
        lookup(3'd5, 16'h001F);
        check_rgb("R7 direct blue field", 8'h00, 8'h00, 8'hFF);
        lookup(3'd5, 16'h1234);
        check_rgb("R7 direct mixed", w5(5'h02), w6(6'h11), w5(5'h14));
    endtask

    task automatic t_black;
        for (int k = 0; k < 8; k++) begin
            if (k == 2 || k == 3 || k == 5) continue;
            lookup(3'(k), 16'hFFFF);
            check_rgb($sformatf("R8 unsupported code %0d", k), 8'h00, 8'h00, 8'h00);
        end
    endtask

    task automatic t_stream;
        @(negedge clk);
        fmt_sel = 3'd5; pix_in = 16'hF81F;
        @(negedge clk);
        check_rgb("R9 stream slot 0", 8'hFF, 8'h00, 8'hFF);
        fmt_sel = 3'd3; pix_in = 16'h0011;
        @(negedge clk);
        check_entry("R9 stream slot 1", 8'h11);
        fmt_sel = 3'd0; pix_in = 16'h0011;
        @(negedge clk);
        check_rgb("R9 stream slot 2", 8'h00, 8'h00, 8'h00);
        fmt_sel = 3'd2; pix_in = 16'h00F2;
        @(negedge clk);
        check_entry("R9 stream slot 3", 8'h02);
    endtask

    task automatic t_collide;
        logic [11:0] old_e;
        host_write(1'b0, 8'h55);
        load_entry(8'h10, 8'h20, 8'h30);
        host_write(1'b0, 8'h55);
        host_write(1'b1, 8'hA0);
        host_write(1'b1, 8'hB0);
        old_e = shadow[8'h55];
        @(negedge clk);
        host_we = 1'b1; host_sel = 1'b1; host_wdata = 8'hC0;
        fmt_sel = 3'd3; pix_in = 16'h0055;
        @(negedge clk);
        host_we = 1'b0;
        shadow[8'h55] = {4'hA, 4'hB, 4'hC};
        check_rgb("R10 collision returns old", w4(old_e[11:8]), w4(old_e[7:4]), w4(old_e[3:0]));
        @(negedge clk);
        check_rgb("R10 new contents after", 8'hAA, 8'hBB, 8'hCC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run_load();
        t_wrap();
        t_restart();
        t_idx256();
        t_idx16();
        t_direct();
        t_black();
        t_stream();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule